// File: doc/BRIEF.md
# Flash-to-RAM Boot Copier

This block moves a program image out of a byte-wide flash and into RAM at start-up, without any processor involvement. When reset is released, it starts reading at a fixed flash base address and interprets what it finds as a chain of records. Each record begins with an eight-byte header: a 32-bit byte count, followed by a 32-bit destination address. After the header come that many payload bytes. The engine writes the payload bytes into RAM one at a time, at consecutive addresses starting from the destination address. It then reads the next header from the flash byte that immediately follows the payload.

Two header values end the walk. A count of zero marks the final record. Its address is the program entry point, and the engine presents it on `entry_addr` together with a one-cycle `jump_valid` strobe. A count of all ones means the flash holds no program. This is the pattern left by an image that carries only configuration data padded with four 0xFF bytes. In that case the engine stops at once, without reading the address word, and raises `halted`. A count larger than a parameterised sanity limit is treated as a corrupt header and raises `error`.

The engine does no other start-up work: it does not clear zero-initialised memory and does not set the stack or global pointers. Those steps belong to the startup code that runs after the jump.

Top module: `flash_boot_copier`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `busy`=1, `fl_req`=1, `fl_addr`=BASE_ADDR, and `done`, `jump_valid`, `halted`, `error` and `ram_we` are all 0.
- R2: Header words are assembled little-endian. Flash bytes B0..B3 form the count (B0 in bits 7:0), and bytes B4..B7 form the destination address in the same byte order.
- R3: For a count L with 0 < L <= MAX_LEN, each accepted payload byte is written to RAM exactly once. The k-th payload byte (k = 0, 1, 2, ...) goes to destination address + k. The write appears on `ram_we`/`ram_addr`/`ram_data` in the cycle after the byte is accepted.
- R4: The next header is read starting at the flash address directly after the last payload byte. Flash reads never skip or repeat an address.
- R5: A count of 0 ends the walk. In the cycle after the last address byte is accepted, `entry_addr` holds the record address, `jump_valid` is high for exactly one cycle, and `done` rises.
- R6: A count of 0xFFFFFFFF raises `halted` and `done` in the cycle after the fourth header byte is accepted. The address word is not read, and no jump is issued.
- R7: A count greater than MAX_LEN raises `error` and `done` in the cycle after the fourth header byte is accepted. No RAM write is issued for that record.
- R8: A flash byte is consumed only in a cycle where `fl_req` and `fl_valid` are both high. While `fl_valid` is low, `fl_addr` holds its value.
- R9: Once `done` is set, `busy` and `fl_req` are low, no RAM write occurs, and `done`, `entry_addr`, `halted` and `error` hold until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fl_req | output | 1 | Flash read request |
| fl_addr | output | FAW | Flash byte address being requested |
| fl_valid | input | 1 | Flash byte on `fl_data` is valid for `fl_addr` |
| fl_data | input | 8 | Flash read data |
| ram_we | output | 1 | RAM byte write strobe |
| ram_addr | output | 32 | RAM write address |
| ram_data | output | 8 | RAM write data |
| busy | output | 1 | Record walk in progress |
| done | output | 1 | Walk finished (jump, halt or error) |
| jump_valid | output | 1 | One-cycle strobe: `entry_addr` is the program entry |
| entry_addr | output | 32 | Program entry address |
| halted | output | 1 | Empty-program marker found |
| error | output | 1 | Header count exceeded MAX_LEN |

## Verification
The bench targets three kinds of faults.

- **Terminator ordering.** An all-ones count must stop the engine after the fourth byte. A design that decoded it only after reading the address would issue four extra flash reads. A design that treated it as a plain count would start copying a huge block.
- **Record boundaries.** A count exactly equal to MAX_LEN must copy, while MAX_LEN+1 must flag an error. Record chains are run with both back-to-back and stalled flash responses. An off-by-one in the remaining-byte counter would show up as a shifted next header, or as one byte too many or too few written.
- **Byte order and jump strobe.** Byte-order mistakes would corrupt `entry_addr` and the write addresses. A jump strobe that lingered would show up as a second `jump_valid` cycle.

// File: rtl/flash_boot_copier.sv
module flash_boot_copier #(
  parameter int          FAW       = 24,
  parameter logic [31:0] BASE_ADDR = 32'h0,
  parameter logic [31:0] MAX_LEN   = 32'h0010_0000
) (
  input  logic           clk,
  input  logic           rst_n,
  output logic           fl_req,
  output logic [FAW-1:0] fl_addr,
  input  logic           fl_valid,
  input  logic [7:0]     fl_data,
  output logic           ram_we,
  output logic [31:0]    ram_addr,
  output logic [7:0]     ram_data,
  output logic           busy,
  output logic           done,
  output logic           jump_valid,
  output logic [31:0]    entry_addr,
  output logic           halted,
  output logic           error
);

  typedef enum logic [1:0] {S_HDR, S_COPY, S_FIN} st_t;

  st_t             st;
  logic [2:0]      idx;
  logic [31:0]     len_q, adr_q, rem_q, wptr;
  logic [FAW-1:0]  rd_ptr;

  wire        take     = (st != S_FIN) && fl_valid;
  wire [31:0] len_full = {fl_data, len_q[23:0]};
  wire [31:0] adr_full = {fl_data, adr_q[23:0]};

  assign fl_req  = (st != S_FIN);
  assign busy    = (st != S_FIN);
  assign fl_addr = rd_ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_HDR;
      idx        <= '0;
      len_q      <= '0;
      adr_q      <= '0;
      rem_q      <= '0;
      wptr       <= '0;
      rd_ptr     <= BASE_ADDR[FAW-1:0];
      ram_we     <= 1'b0;
      ram_addr   <= '0;
      ram_data   <= '0;
      done       <= 1'b0;
      jump_valid <= 1'b0;
      entry_addr <= '0;
      halted     <= 1'b0;
      error      <= 1'b0;
    end else begin
      ram_we     <= 1'b0;
      jump_valid <= 1'b0;
      if (take) begin
        rd_ptr <= rd_ptr + 1'b1;
        case (st)
          S_HDR: begin
            if (!idx[2]) len_q[{idx[1:0], 3'b000} +: 8] <= fl_data;
            else         adr_q[{idx[1:0], 3'b000} +: 8] <= fl_data;
            idx <= idx + 1'b1;
            if (idx == 3'd3) begin
              if (&len_full) begin
                halted <= 1'b1;
                done   <= 1'b1;
                st     <= S_FIN;
              end else if (len_full > MAX_LEN) begin
                error <= 1'b1;
                done  <= 1'b1;
                st    <= S_FIN;
              end
            end
            if (idx == 3'd7) begin
              if (len_q == 32'd0) begin
                entry_addr <= adr_full;
                jump_valid <= 1'b1;
                done       <= 1'b1;
                st         <= S_FIN;
              end else begin
                rem_q <= len_q;
                wptr  <= adr_full;
                st    <= S_COPY;
              end
            end
          end
          S_COPY: begin
            ram_we   <= 1'b1;
            ram_addr <= wptr;
            ram_data <= fl_data;
            wptr     <= wptr + 32'd1;
            rem_q    <= rem_q - 32'd1;
            if (rem_q == 32'd1) begin
              st  <= S_HDR;
              idx <= '0;
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/flash_boot_copier_chk.sv
module flash_boot_copier_chk #(
  parameter int FAW = 24
) (
  input logic           clk,
  input logic           rst_n,
  input logic           fl_req,
  input logic [FAW-1:0] fl_addr,
  input logic           fl_valid,
  input logic           ram_we,
  input logic           busy,
  input logic           done,
  input logic           jump_valid,
  input logic [31:0]    entry_addr,
  input logic           halted,
  input logic           error
);

  // R8
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_req && !fl_valid) |=> (fl_req && $stable(fl_addr)));

  // R5
  jump_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    jump_valid |=> !jump_valid);

  // R5
  jump_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    jump_valid |-> (done && !halted && !error));

  // R6
  halt_nojump_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> (done && !jump_valid && !error));

  // R7
  err_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> (done && !ram_we && !jump_valid));

  // R9
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !fl_req && !ram_we));

  // R9
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (done && $stable(entry_addr) && $stable(halted) && $stable(error)));

endmodule

bind flash_boot_copier flash_boot_copier_chk #(.FAW(FAW)) u_chk (
  .clk(clk), .rst_n(rst_n), .fl_req(fl_req), .fl_addr(fl_addr),
  .fl_valid(fl_valid), .ram_we(ram_we), .busy(busy), .done(done),
  .jump_valid(jump_valid), .entry_addr(entry_addr), .halted(halted),
  .error(error)
);

// File: tb/flash_boot_copier_bench.sv
module flash_boot_copier_bench;
  localparam int          FAW  = 24;
  localparam logic [31:0] BASE = 32'd16;
  localparam logic [31:0] MAXL = 32'd40;

  logic clk = 0, rst_n = 0;
  logic fl_req, fl_valid = 0, ram_we, busy, done, jump_valid, halted, error;
  logic [FAW-1:0] fl_addr;
  logic [7:0] fl_data = 0, ram_data;
  logic [31:0] ram_addr, entry_addr;

  always #5 clk = ~clk;

  flash_boot_copier #(.FAW(FAW), .BASE_ADDR(BASE), .MAX_LEN(MAXL)) u_flash_boot_copier (
    .clk(clk), .rst_n(rst_n), .fl_req(fl_req), .fl_addr(fl_addr),
    .fl_valid(fl_valid), .fl_data(fl_data), .ram_we(ram_we),
    .ram_addr(ram_addr), .ram_data(ram_data), .busy(busy), .done(done),
    .jump_valid(jump_valid), .entry_addr(entry_addr), .halted(halted),
    .error(error));

  int checks = 0, fails = 0, cyc = 0;
  logic [7:0] fmem [0:511];
  bit stall = 0, comp_en = 0;
  int wcount = 0, jcount = 0;

  // behavioural reference
  int m_ph, m_idx;
  logic [31:0] m_L, m_A, m_rem, m_wa, m_fa;
  logic e_we, e_jump, e_done, e_halt, e_err;
  logic [31:0] e_wa, e_entry;
  logic [7:0] e_wd;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_ph = 0; m_idx = 0; m_L = 0; m_A = 0; m_rem = 0; m_wa = 0; m_fa = BASE;
      e_we = 0; e_jump = 0; e_done = 0; e_halt = 0; e_err = 0;
      e_wa = 0; e_wd = 0; e_entry = 0;
    end else begin
      e_we = 0; e_jump = 0;
      if (m_ph != 2 && fl_valid) begin
        m_fa = m_fa + 1;
        if (m_ph == 0) begin
          if (m_idx < 4) m_L = m_L | (32'(fl_data) << (8 * m_idx));
          else           m_A = m_A | (32'(fl_data) << (8 * (m_idx - 4)));
          if (m_idx == 3 && m_L == 32'hFFFF_FFFF) begin
            e_halt = 1; e_done = 1; m_ph = 2;
          end else if (m_idx == 3 && m_L > MAXL) begin
            e_err = 1; e_done = 1; m_ph = 2;
          end else if (m_idx == 7) begin
            if (m_L == 0) begin
              e_entry = m_A; e_jump = 1; e_done = 1; m_ph = 2;
            end else begin
              m_ph = 1; m_rem = m_L; m_wa = m_A;
            end
          end else m_idx++;
        end else begin
          e_we = 1; e_wa = m_wa; e_wd = fl_data;
          m_wa++; m_rem--;
          if (m_rem == 0) begin m_ph = 0; m_idx = 0; m_L = 0; m_A = 0; end
        end
      end
    end
  end

  always @(negedge clk) begin
    if (comp_en) begin
      chk(fl_req == (m_ph != 2), "R8", "fl_req", 32'(fl_req), 32'(m_ph != 2));
      chk(32'(fl_addr) == m_fa, "R4", "fl_addr", 32'(fl_addr), m_fa);
      chk(ram_we == e_we, "R3", "ram_we", 32'(ram_we), 32'(e_we));
      if (e_we) begin
        chk(ram_addr == e_wa, "R3", "ram_addr", ram_addr, e_wa);
        chk(ram_data == e_wd, "R3", "ram_data", 32'(ram_data), 32'(e_wd));
      end
      chk(jump_valid == e_jump, "R5", "jump_valid", 32'(jump_valid), 32'(e_jump));
      chk(entry_addr == e_entry, "R5", "entry_addr", entry_addr, e_entry);
      chk(halted == e_halt, "R6", "halted", 32'(halted), 32'(e_halt));
      chk(error == e_err, "R7", "error", 32'(error), 32'(e_err));
      chk(done == e_done && busy == !e_done, "R9", "done/busy",
          {30'd0, done, busy}, {30'd0, e_done, !e_done});
      if (ram_we) wcount++;
      if (jump_valid) jcount++;
    end
    fl_valid = fl_req && (!stall || (cyc % 3 != 1));
    fl_data  = fmem[fl_addr[8:0]];
  end

  initial begin
    int wd = 0;
    while (wd < 150000) begin @(posedge clk); wd++; end
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  int fp;
  task automatic clear_flash();
    for (int i = 0; i < 512; i++) fmem[i] = 8'h00;
    fp = int'(BASE);
  endtask
  task automatic put_word(input logic [31:0] w);
    for (int i = 0; i < 4; i++) begin fmem[fp] = w[8*i +: 8]; fp++; end
  endtask
  task automatic put_rec(input logic [31:0] len, input logic [31:0] adr, input logic [7:0] seed);
    put_word(len); put_word(adr);
    for (int i = 0; i < int'(len); i++) begin fmem[fp] = seed + 8'(i * 7); fp++; end
  endtask

  task automatic run(input bit st, input bit exp_jump, input logic [31:0] exp_entry,
                     input bit exp_halt, input bit exp_err, input int exp_writes,
                     input logic [31:0] exp_fa);
    int n = 0;
    comp_en = 0; stall = st;
    @(negedge clk); rst_n = 0;
    repeat (2) @(negedge clk);
    // R1
    chk(busy && fl_req && !done && !jump_valid && !halted && !error && !ram_we
        && 32'(fl_addr) == BASE, "R1", "reset state",
        {25'd0, busy, fl_req, done, jump_valid, halted, error, ram_we}, 32'h60);
    rst_n = 1; wcount = 0; jcount = 0;
    @(negedge clk); comp_en = 1;
    while (!done && n < 2000) begin @(negedge clk); n++; end
    repeat (4) @(negedge clk);
    comp_en = 0;
    chk(done == 1'b1, "R9", "done reached", 32'(done), 1);
    chk(jcount == int'(exp_jump), "R5", "jump count", jcount, 32'(exp_jump));
    if (exp_jump) chk(entry_addr == exp_entry, "R2", "entry word order", entry_addr, exp_entry);
    chk(halted == exp_halt, "R6", "halted final", 32'(halted), 32'(exp_halt));
    chk(error == exp_err, "R7", "error final", 32'(error), 32'(exp_err));
    chk(wcount == exp_writes, "R3", "write count", wcount, exp_writes);
    chk(32'(fl_addr) == exp_fa, "R4", "final flash pointer", 32'(fl_addr), exp_fa);
  endtask

  initial begin
    // two records then jump, no stalls, then stalled
    for (int s = 0; s < 2; s++) begin
      clear_flash();
      put_rec(5, 32'h2000_0100, 8'h11);
      put_rec(1, 32'h3000_0000, 8'hAB);
      put_word(0); put_word(32'h1234_ABCD);
      run(s[0], 1, 32'h1234_ABCD, 0, 0, 6, BASE + 8 + 5 + 8 + 1 + 8);
    end
    // configuration-only image: four 0xFF then zeros
    clear_flash();
    put_word(32'hFFFF_FFFF);
    run(0, 0, 0, 1, 0, 0, BASE + 4);
    // record then halt marker, stalled
    clear_flash();
    put_rec(3, 32'h0000_0040, 8'h5A);
    put_word(32'hFFFF_FFFF); put_word(32'h0BAD_0BAD);
    run(1, 0, 0, 1, 0, 3, BASE + 8 + 3 + 4);
    // oversize count
    clear_flash();
    put_rec(0, 0, 0); fp = int'(BASE);
    put_word(MAXL + 1); put_word(32'h0000_1000);
    run(0, 0, 0, 0, 1, 0, BASE + 4);
    // count exactly at limit
    clear_flash();
    put_rec(MAXL, 32'h8000_0000, 8'h03);
    put_word(0); put_word(32'hCAFE_F00D);
    run(1, 1, 32'hCAFE_F00D, 0, 0, int'(MAXL), BASE + 8 + MAXL + 8);
    // immediate jump
    clear_flash();
    put_word(0); put_word(32'h0403_0201);
    run(0, 1, 32'h0403_0201, 0, 0, 0, BASE + 8);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule